// File: doc/BRIEF.md
# SDRAM Burst Read Path

This block is the device-side read path of a 16-bit synchronous DRAM bank model. When a read command arrives for a bank that is open, the block takes the starting column from that command. It then works out the rest of the burst addresses itself and reads the stored words. Each word is driven onto the data pins after a CAS latency of two or three clocks, which is chosen by a configuration pin. The block also models the pin drivers. An enable output per byte lane opens the drive window one clock before the first word. The window closes by itself after the last word of a finite burst. In full-page mode the burst keeps wrapping through the row until a burst-stop command arrives.

The read data stream has a valid strobe but no ready. The memory side cannot stall, so back-pressure is not accepted. A consumer must take every word in the clock where `dq_valid` is high. The byte masks, the commands and the configuration are plain level pins, sampled at each rising clock edge. A small write port fills the word storage so that the read path has contents to return.

Top module: `sdr_read_path`

## Requirements
- R1: With `cas_sel`=0 the first word of a burst is presented two clocks after the rising edge that samples the read; with `cas_sel`=1 it is three clocks after. `dq_valid` marks each data clock.
- R2: The first word comes from the column given with the read. Each following clock presents the next column. The column wraps inside the aligned block of the burst length, so only the low bits count up. `bl_sel` codes 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 words.
- R3: Both bits of `dq_oe` rise one clock before the first word, while `dq_valid` is still low.
- R4: After the last word of a finite burst, `dq_valid`, `dq_oe` and `dq_out` fall to zero in the next clock, unless another burst follows without a gap.
- R5: A `bl_sel` code of 4 to 7 selects full page. The column wraps through all 16 columns without end. A burst-stop sampled at edge s lets only the words generated before edge s come out, and then the drivers turn off.
- R6: `byte_mask` bit 1 masks the upper byte and bit 0 masks the lower byte. A mask bit sampled at edge j acts on the word presented after edge j+2, whatever the CAS latency. A masked byte has its `dq_oe` bit low and reads as zero.
- R7: A read starts a burst only if the `bank_active` bit for its bank is set when the read is sampled.
- R8: A read to a bank whose bit is clear raises `rd_err` for exactly one clock after that edge. It starts nothing, and any burst already under way goes on unchanged.
- R9: A valid read during a burst ends that burst. Words of the old burst generated before the new read still come out. The new burst follows them with its own latency and no gap.
- R10: If a read and a burst-stop are sampled at the same edge, the read wins.
- R11: While reset is asserted, `dq_valid`, `dq_oe`, `dq_out` and `rd_err` are all zero.
- R12: A write-port strobe stores `wr_data` at the given bank and column, and a later read returns that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cas_sel | input | 1 | CAS latency select: 0 gives two clocks, 1 gives three |
| bl_sel | input | 3 | Burst length code, sampled together with a read |
| bank_active | input | 2 | One open flag per bank |
| cmd_read | input | 1 | Read command |
| cmd_stop | input | 1 | Burst-stop command |
| rd_bank | input | 1 | Bank of the read |
| rd_col | input | 4 | Starting column of the read |
| byte_mask | input | 2 | Output byte masks, bit 1 upper and bit 0 lower |
| wr_en | input | 1 | Storage fill strobe |
| wr_bank | input | 1 | Fill bank |
| wr_col | input | 4 | Fill column |
| wr_data | input | 16 | Fill word |
| dq_out | output | 16 | Read data, zero when not driven |
| dq_oe | output | 2 | Driver enable per byte lane |
| dq_valid | output | 1 | Data clock strobe |
| rd_err | output | 1 | Read to a closed bank |

## Verification
The read function is driven first with directed bursts of every finite length, started at columns inside a block so that the wrap point is visible. Full-page bursts are run past the end of the row and then stopped. Bursts are also cut short by a new read two clocks in, and a read and a stop are issued on the same edge. Together these patterns separate a correct burst counter from one with a wrong increment, a wrong alignment, a missed truncation or the wrong command priority. The random phase mixes reads, stops, closed banks and byte masks at both latencies. These patterns show whether the mask delay is tied to the data latency when it should not be, and whether overlapping bursts join seamlessly.

// File: rtl/sdr_rd_pkg.sv
`timescale 1ns/1ps
package sdr_rd_pkg;
  localparam int COL_W  = 4;
  localparam int BANK_W = 1;
  localparam int NBANK  = 1 << BANK_W;
  localparam int NCOL   = 1 << COL_W;

  typedef logic [COL_W-1:0]  col_t;
  typedef logic [BANK_W-1:0] bank_t;

  // one word request travelling toward the pins
  typedef struct packed {
    logic  vld;
    bank_t bank;
    col_t  col;
  } slot_t;

  // low column bits that count inside a burst block; full page counts all
  function automatic col_t wrap_mask(input logic [2:0] code);
    if (code[2]) return '1;
    return col_t'((1 << code[1:0]) - 1);
  endfunction

  function automatic col_t next_col(input col_t c, input col_t m);
    return (c & ~m) | ((c + col_t'(1)) & m);
  endfunction
endpackage

// File: rtl/sdr_burst_gen.sv
`timescale 1ns/1ps
module sdr_burst_gen
  import sdr_rd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       stop,
  input  bank_t      st_bank,
  input  col_t       st_col,
  input  logic [2:0] bl_code,
  output slot_t      slot_o,
  output logic       busy_o
);
  slot_t slot_q;
  logic  run_q, full_q;
  col_t  col_q, m_q, left_q, m_new;
  bank_t bank_q;

  assign m_new = wrap_mask(bl_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      run_q  <= 1'b0;
      full_q <= 1'b0;
      col_q  <= '0;
      m_q    <= '0;
      left_q <= '0;
      bank_q <= '0;
    end else if (start) begin
      slot_q <= '{vld: 1'b1, bank: st_bank, col: st_col};
      bank_q <= st_bank;
      m_q    <= m_new;
      col_q  <= next_col(st_col, m_new);
      left_q <= m_new;
      full_q <= bl_code[2];
      run_q  <= bl_code[2] || (m_new != '0);
    end else if (stop) begin
      slot_q.vld <= 1'b0;
      run_q      <= 1'b0;
    end else if (run_q) begin
      slot_q <= '{vld: 1'b1, bank: bank_q, col: col_q};
      col_q  <= next_col(col_q, m_q);
      left_q <= left_q - col_t'(1);
      if (!full_q && left_q == col_t'(1)) run_q <= 1'b0;
    end else begin
      slot_q.vld <= 1'b0;
    end
  end

  assign slot_o = slot_q;
  assign busy_o = run_q;
endmodule

// File: rtl/sdr_lat_pipe.sv
`timescale 1ns/1ps
module sdr_lat_pipe
  import sdr_rd_pkg::*;
#(
  parameter int MIN_LAT = 2,
  parameter int LSEL_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LSEL_W-1:0] lat_sel,
  input  slot_t             s_in,
  output slot_t             tap_o,
  output slot_t             pre_o
);
  localparam int MAX_LAT = MIN_LAT + (1 << LSEL_W) - 1;

  slot_t r [MAX_LAT];
  int    tap_idx, pre_idx;

  genvar i;
  generate
    for (i = 1; i < MAX_LAT; i++) begin : g_stage
      if (i == 1) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) r[i] <= '0;
          else        r[i] <= s_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) r[i] <= '0;
          else        r[i] <= r[i-1];
      end
    end
  endgenerate

  // stage feeding the pin register, and the stage one step behind it
  assign tap_idx = MIN_LAT - 1 + int'(lat_sel);
  assign pre_idx = tap_idx - 1;

  always_comb begin
    tap_o = '0;
    pre_o = s_in;
    for (int k = 1; k < MAX_LAT; k++) begin
      if (k == tap_idx) tap_o = r[k];
      if (k == pre_idx) pre_o = r[k];
    end
  end
endmodule

// File: rtl/sdr_mask_delay.sv
`timescale 1ns/1ps
module sdr_mask_delay #(
  parameter int NB       = 2,
  parameter int MASK_LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] m_in,
  output logic [NB-1:0] m_out
);
  logic [NB-1:0] d [MASK_LAT];

  genvar i;
  generate
    for (i = 0; i < MASK_LAT; i++) begin : g_dly
      if (i == 0) begin : g_head
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) d[i] <= '0;
          else        d[i] <= m_in;
      end else begin : g_tail
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) d[i] <= '0;
          else        d[i] <= d[i-1];
      end
    end
  endgenerate

  assign m_out = d[MASK_LAT-1];
endmodule

// File: rtl/sdr_word_store.sv
`timescale 1ns/1ps
module sdr_word_store
  import sdr_rd_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          wr_en,
  input  bank_t         wr_bank,
  input  col_t          wr_col,
  input  logic [DW-1:0] wr_data,
  input  bank_t         rd_bank,
  input  col_t          rd_col,
  output logic [DW-1:0] rd_word
);
  localparam int DEPTH = NBANK * NCOL;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk)
    if (wr_en) mem[{wr_bank, wr_col}] <= wr_data;

  assign rd_word = mem[{rd_bank, rd_col}];
endmodule

// File: rtl/sdr_read_path.sv
`timescale 1ns/1ps
module sdr_read_path
  import sdr_rd_pkg::*;
#(
  parameter int DW       = 16,
  parameter int MIN_LAT  = 2,
  parameter int LSEL_W   = 1,
  parameter int MASK_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LSEL_W-1:0] cas_sel,
  input  logic [2:0]        bl_sel,
  input  logic [NBANK-1:0]  bank_active,
  input  logic              cmd_read,
  input  logic              cmd_stop,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [COL_W-1:0]  rd_col,
  input  logic [DW/8-1:0]   byte_mask,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] wr_bank,
  input  logic [COL_W-1:0]  wr_col,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     dq_out,
  output logic [DW/8-1:0]   dq_oe,
  output logic              dq_valid,
  output logic              rd_err
);
  localparam int NB = DW / 8;

  logic          read_ok, bad_read;
  slot_t         gen_slot, tap_slot, pre_slot;
  logic          gen_busy;
  logic [NB-1:0] mask_d;
  logic [DW-1:0] word;

  logic [DW-1:0] dq_q;
  logic [NB-1:0] oe_q;
  logic          vld_q, err_q;

  assign read_ok  = cmd_read &  bank_active[rd_bank];
  assign bad_read = cmd_read & ~bank_active[rd_bank];

  sdr_burst_gen u_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (read_ok),
    .stop    (cmd_stop),
    .st_bank (rd_bank),
    .st_col  (rd_col),
    .bl_code (bl_sel),
    .slot_o  (gen_slot),
    .busy_o  (gen_busy)
  );

  sdr_lat_pipe #(.MIN_LAT(MIN_LAT), .LSEL_W(LSEL_W)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .lat_sel (cas_sel),
    .s_in    (gen_slot),
    .tap_o   (tap_slot),
    .pre_o   (pre_slot)
  );

  sdr_mask_delay #(.NB(NB), .MASK_LAT(MASK_LAT)) u_mask (
    .clk   (clk),
    .rst_n (rst_n),
    .m_in  (byte_mask),
    .m_out (mask_d)
  );

  sdr_word_store #(.DW(DW)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_bank (wr_bank),
    .wr_col  (wr_col),
    .wr_data (wr_data),
    .rd_bank (tap_slot.bank),
    .rd_col  (tap_slot.col),
    .rd_word (word)
  );

  // pin register: drive window opens with the stage ahead of the data
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_q  <= '0;
      oe_q  <= '0;
      vld_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      vld_q <= tap_slot.vld;
      err_q <= bad_read;
      for (int b = 0; b < NB; b++) begin
        dq_q[b*8 +: 8] <= (tap_slot.vld && !mask_d[b]) ? word[b*8 +: 8] : 8'h00;
        oe_q[b]        <= (pre_slot.vld | tap_slot.vld) & ~(tap_slot.vld & mask_d[b]);
      end
    end
  end

  assign dq_out   = dq_q;
  assign dq_oe    = oe_q;
  assign dq_valid = vld_q;
  assign rd_err   = err_q;
endmodule

// File: rtl/sdr_read_path_chk.sv
`timescale 1ns/1ps
module sdr_read_path_chk
  import sdr_rd_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cas_sel,
  input logic             cmd_read,
  input logic             cmd_stop,
  input logic [NBANK-1:0] bank_active,
  input bank_t            rd_bank,
  input logic [1:0]       byte_mask,
  input logic [15:0]      dq_out,
  input logic [1:0]       dq_oe,
  input logic             dq_valid,
  input logic             rd_err,
  input slot_t            gen_slot,
  input logic             gen_busy
);
  assert_lat2_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_slot.vld && !cas_sel) ##1 !cas_sel |=> dq_valid);

  assert_lat3_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_slot.vld && cas_sel) ##1 cas_sel ##1 cas_sel |=> dq_valid);

  assert_preamble_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_valid) |-> $past(dq_oe) == 2'b11);

  assert_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop && !cmd_read |=> !gen_slot.vld && !gen_busy);

  assert_mask_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dq_valid && $past(byte_mask[0], 3) |-> !dq_oe[0] && dq_out[7:0] == 8'h00);

  assert_mask_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dq_valid && $past(byte_mask[1], 3) |-> !dq_oe[1] && dq_out[15:8] == 8'h00);

  assert_unmasked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dq_valid && $past(byte_mask, 3) == 2'b00 |-> dq_oe == 2'b11);

  assert_bad_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_read && !bank_active[rd_bank] && !gen_busy |=> rd_err && !gen_slot.vld);
endmodule

bind sdr_read_path sdr_read_path_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cas_sel     (cas_sel),
  .cmd_read    (cmd_read),
  .cmd_stop    (cmd_stop),
  .bank_active (bank_active),
  .rd_bank     (rd_bank),
  .byte_mask   (byte_mask),
  .dq_out      (dq_out),
  .dq_oe       (dq_oe),
  .dq_valid    (dq_valid),
  .rd_err      (rd_err),
  .gen_slot    (gen_slot),
  .gen_busy    (gen_busy)
);

// File: tb/sdr_read_path_tb.sv
`timescale 1ns/1ps
module sdr_read_path_tb_top;
  import sdr_rd_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        cas_sel;
  logic [2:0]  bl_sel;
  logic [1:0]  bank_active;
  logic        cmd_read, cmd_stop;
  bank_t       rd_bank;
  col_t        rd_col;
  logic [1:0]  byte_mask;
  logic        wr_en;
  bank_t       wr_bank;
  col_t        wr_col;
  logic [15:0] wr_data;
  logic [15:0] dq_out;
  logic [1:0]  dq_oe;
  logic        dq_valid, rd_err;

  sdr_read_path dut_i (
    .clk(clk), .rst_n(rst_n), .cas_sel(cas_sel), .bl_sel(bl_sel),
    .bank_active(bank_active), .cmd_read(cmd_read), .cmd_stop(cmd_stop),
    .rd_bank(rd_bank), .rd_col(rd_col), .byte_mask(byte_mask),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_col(wr_col), .wr_data(wr_data),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_valid(dq_valid), .rd_err(rd_err)
  );

  int    total = 0, bad = 0, ecnt = 0;
  bit    done = 1'b0;
  string phase = "R11 reset";

  logic [15:0] mem_m [NBANK][NCOL];
  bit          sv [8];
  bank_t       sb [8];
  col_t        sc [8];
  logic [1:0]  mh [8];
  bit          se [8];

  bit    b_act, b_full;
  int    b_edge, b_len;
  bank_t b_bank;
  col_t  b_col, b_m;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s [%s] cycle %0d act=%h exp=%h", req, phase, ecnt, act, exp);
    end
  endtask

  // burst model: word i of a burst started at edge b_edge is emitted at
  // edge b_edge+i and reaches the pins after the CAS latency
  task automatic model_edge(input int e);
    int lat, i, slot;
    lat = cas_sel ? 3 : 2;
    mh[e % 8] = byte_mask;
    se[e % 8] = cmd_read && !bank_active[rd_bank];
    if (cmd_read && bank_active[rd_bank]) begin
      b_act  = 1'b1;
      b_edge = e;
      b_bank = rd_bank;
      b_col  = rd_col;
      b_full = bl_sel[2];
      b_len  = 1 << bl_sel[1:0];
      b_m    = b_full ? '1 : col_t'(b_len - 1);
    end else if (cmd_stop) begin
      b_act = 1'b0;
    end
    if (b_act) begin
      i = e - b_edge;
      if (b_full || i < b_len) begin
        slot     = (e + lat) % 8;
        sv[slot] = 1'b1;
        sb[slot] = b_bank;
        sc[slot] = (b_col & ~b_m) | (col_t'(int'(b_col) + i) & b_m);
      end else begin
        b_act = 1'b0;
      end
    end
  endtask

  task automatic check_cycle(input int t);
    bit          ev, nv;
    logic [1:0]  mk, eo;
    logic [15:0] w, ed;
    ev = sv[t % 8];
    nv = sv[(t + 1) % 8];
    mk = (t >= 2) ? mh[(t - 2) % 8] : 2'b00;
    w  = ev ? mem_m[sb[t % 8]][sc[t % 8]] : 16'h0000;
    for (int b = 0; b < 2; b++) begin
      ed[b*8 +: 8] = (ev && !mk[b]) ? w[b*8 +: 8] : 8'h00;
      eo[b]        = (ev | nv) & !(ev & mk[b]);
    end
    chk(dq_valid == ev, "R1 valid timing", 32'(dq_valid), 32'(ev));
    chk(dq_out == ed, "R2 data order, R6 masking", 32'(dq_out), 32'(ed));
    chk(dq_oe == eo, "R3 R4 drive window", 32'(dq_oe), 32'(eo));
    chk(rd_err == se[t % 8], "R8 R7 bank check", 32'(rd_err), 32'(se[t % 8]));
  endtask

  task automatic tick();
    model_edge(ecnt);
    @(posedge clk);
    @(negedge clk);
    check_cycle(ecnt);
    sv[ecnt % 8] = 1'b0;
    ecnt++;
  endtask

  task automatic idle(input int n);
    cmd_read  = 1'b0;
    cmd_stop  = 1'b0;
    byte_mask = 2'b00;
    repeat (n) tick();
  endtask

  task automatic rd(input int bank, input int col);
    rd_bank  = bank_t'(bank);
    rd_col   = col_t'(col);
    cmd_read = 1'b1;
    tick();
    cmd_read = 1'b0;
  endtask

  task automatic stop_now();
    cmd_stop = 1'b1;
    tick();
    cmd_stop = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 act=running exp=finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int k = 0; k < 8; k++) begin sv[k] = 0; se[k] = 0; mh[k] = 0; sb[k] = 0; sc[k] = 0; end
    b_act = 0; b_full = 0; b_edge = 0; b_len = 0; b_bank = 0; b_col = 0; b_m = 0;
    rst_n = 1'b0; cas_sel = 1'b0; bl_sel = 3'd2; bank_active = 2'b11;
    cmd_read = 1'b0; cmd_stop = 1'b0; rd_bank = '0; rd_col = '0; byte_mask = 2'b00;
    wr_en = 1'b0; wr_bank = '0; wr_col = '0; wr_data = '0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dq_valid == 1'b0 && dq_oe == 2'b00 && dq_out == 16'h0 && rd_err == 1'b0,
        "R11 reset state", {13'h0, dq_valid, dq_oe, dq_out}, 32'h0);
    rst_n = 1'b1;
    ecnt  = 1;

    phase = "R12 fill";
    for (int b = 0; b < NBANK; b++)
      for (int c = 0; c < NCOL; c++) begin
        wr_en   = 1'b1;
        wr_bank = bank_t'(b);
        wr_col  = col_t'(c);
        wr_data = 16'($urandom);
        mem_m[b][c] = wr_data;
        tick();
      end
    wr_en = 1'b0;
    idle(2);

    phase = "R1 R2 R4 R12 CL2 burst of 4 from column 6";
    cas_sel = 1'b0; bl_sel = 3'd2;
    rd(0, 6); idle(6);

    phase = "R1 R2 R4 CL3 burst of 8 from column 13";
    cas_sel = 1'b1; bl_sel = 3'd3;
    rd(1, 13); idle(10);

    phase = "R2 R4 bursts of 1 and 2";
    bl_sel = 3'd0; rd(0, 9); idle(5);
    bl_sel = 3'd1; rd(1, 7); idle(5);

    phase = "R5 full page wrap then stop";
    cas_sel = 1'b0; bl_sel = 3'd4;
    rd(0, 14); idle(20); stop_now(); idle(6);

    phase = "R6 mask delay at CL3";
    cas_sel = 1'b1; bl_sel = 3'd3;
    rd(1, 0);
    byte_mask = 2'b01; tick();
    byte_mask = 2'b10; tick();
    byte_mask = 2'b11; tick();
    byte_mask = 2'b00; tick();
    idle(8);

    phase = "R8 R7 read to closed bank while idle";
    bank_active = 2'b01;
    rd(1, 3); idle(6);

    phase = "R8 closed-bank read during a burst";
    bl_sel = 3'd3;
    rd(0, 2); tick(); rd(1, 5); idle(10);
    bank_active = 2'b11;

    phase = "R9 new read truncates burst";
    cas_sel = 1'b0; bl_sel = 3'd3;
    rd(0, 4); tick(); bl_sel = 3'd2; rd(1, 10); idle(8);

    phase = "R10 read and stop on the same edge";
    bl_sel = 3'd5;
    rd(1, 1); idle(3);
    bl_sel = 3'd1; cmd_stop = 1'b1; rd(0, 11); cmd_stop = 1'b0; idle(6);

    for (int cl = 0; cl < 2; cl++) begin
      phase   = cl == 0 ? "R9 R5 R6 random mix CL2" : "R9 R5 R6 random mix CL3";
      cas_sel = cl[0];
      for (int k = 0; k < 500; k++) begin
        int r;
        r           = int'($urandom % 12);
        cmd_read    = (r < 2);
        cmd_stop    = (r == 2 || r == 3);
        rd_bank     = bank_t'($urandom);
        rd_col      = col_t'($urandom);
        bl_sel      = 3'($urandom);
        bank_active = 2'($urandom);
        byte_mask   = ($urandom % 4 == 0) ? 2'($urandom) : 2'b00;
        tick();
      end
      idle(1); stop_now(); idle(8);
      bank_active = 2'b11;
    end

    finish_run();
  end
endmodule